// File: doc/BRIEF.md
# Warp Issue Scheduler with Load Scoreboard

This block chooses, every clock, which of a fixed set of resident warps sends its next instruction to an execution-unit set. Each warp presents the descriptor of its next instruction (the head) and, optionally, of the instruction after it (the pair). A per-warp, per-register scoreboard records which registers still wait on a memory load. A warp whose head touches such a register is passed over, and any other eligible warp issues in the same cycle. Register state stays with its warp, so changing the issuing warp costs no cycles.

A load does not stall the warp that issued it. The warp keeps issuing instructions that do not use the pending register. A load-return beat tagged with warp and register clears the pending mark. When the dual-issue variant is built in, the head and the pair of the selected warp can both issue in one cycle, provided they are independent and go to two different unit sets. Instruction fetch, decode and the execution datapaths sit outside this block. Its issue outputs tell those stages which warp advanced and by how many instructions.

Top module: `wis_issue_top`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `issue_valid` is 0. Reset clears every pending mark and sets the arbitration pointer so that warp 0 has first priority.
- R2: A warp can issue only if its `warp_ready` bit is set and the unit set named by its head is not busy. Unit codes of `NUM_UNITS` or above never issue. With no eligible warp, `issue_valid` is 0.
- R3: Among eligible warps, selection is round-robin. The search starts at the warp after the one that last issued and wraps around. A cycle with no issue leaves the pointer unchanged.
- R4: An issued load (unit code `LOAD_UNIT`, default 2) marks its destination register pending for its warp from the next cycle. A warp whose head reads or writes a pending register is skipped, and in that same cycle another eligible warp issues.
- R5: A return beat (`ret_valid`, `ret_warp`, `ret_reg`) clears that one pending mark. The waiting warp becomes eligible in the cycle after the beat, not in the cycle of the beat.
- R6: A warp with an outstanding load keeps issuing head instructions that neither read nor write the pending register.
- R7: The pair also issues (`issue_valid[1]`) only when all of these hold: `pair_valid` is set for the selected warp; the pair's unit differs from the head's unit and is not busy; the pair's sources and destination all differ from the head's destination; and none of the pair's registers is pending. A load issued as the pair sets its own pending mark.
- R8: `issue_valid[0]` reports the head, and `issue_valid[1]` reports the pair of the same warp `issue_warp`. `issue_valid[1]` is never set without `issue_valid[0]`. `issue_unit0` and `issue_unit1` carry the unit codes of the head and the pair.
- R9: Descriptor encoding, 11 bits per warp: bits [2:0] first source, [5:3] second source, [8:6] destination, [10:9] unit code (0 ALU set, 1 special-function set, 2 load/store set). Warp g's descriptor sits at bits [g*11+10 : g*11] of the flat bus.
- R10: Pending marks are kept per warp. A return beat for one warp leaves the marks of every other warp unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| warp_ready | input | NUM_WARPS | Warp has a valid head instruction |
| head_desc | input | NUM_WARPS*11 | Head descriptor of each warp |
| pair_valid | input | NUM_WARPS | Warp has a valid pair instruction |
| pair_desc | input | NUM_WARPS*11 | Pair descriptor of each warp |
| unit_busy | input | NUM_UNITS | Unit set cannot accept an instruction this cycle |
| ret_valid | input | 1 | Load-return beat |
| ret_warp | input | log2(NUM_WARPS) | Warp of the returning load |
| ret_reg | input | 3 | Register of the returning load |
| issue_valid | output | 2 | Bit 0 head issued, bit 1 pair issued |
| issue_warp | output | log2(NUM_WARPS) | Warp that issued |
| issue_unit0 | output | 2 | Unit code of the head |
| issue_unit1 | output | 2 | Unit code of the pair |

## Verification
A pending mark that is stuck set shows at the ports as a warp that never issues again: it is skipped in the cycle after the missing clear. A mark that was never set, or was lost, shows as an issue in the very cycle the dependent head is presented. A wrong round-robin pointer shifts the issuing warp on the next cycle where more than one warp is eligible. A bad pair check shows as `issue_valid[1]` being wrong in the same cycle. The test vectors place these cases back to back, so any of these faults is caught within one or two cycles.

// File: rtl/wis_pkg.sv
// Package: shared descriptor layout and field widths for the warp issue scheduler.
// Assumes every instruction names two sources and one destination register.
package wis_pkg;
    localparam int REG_W  = 3;
    localparam int UNIT_W = 2;
    localparam int NUM_REGS = 1 << REG_W;
    localparam int DESC_W = UNIT_W + 3 * REG_W;

    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src1;
        logic [REG_W-1:0]  src0;
    } desc_t;
endpackage

// File: rtl/wis_scoreboard.sv
// Module: pending-load scoreboard, one bit per warp per register.
// Up to two set requests from the same warp and one clear per cycle; a set
// wins over a clear of the same bit. Assumes clears only target loaded registers.
module wis_scoreboard #(
    parameter int NUM_WARPS = 4,
    parameter int NUM_REGS  = 8,
    localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int RID_W = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set0_en,
    input  logic                          set1_en,
    input  logic [WID_W-1:0]              set_warp,
    input  logic [RID_W-1:0]              set0_reg,
    input  logic [RID_W-1:0]              set1_reg,
    input  logic                          clr_en,
    input  logic [WID_W-1:0]              clr_warp,
    input  logic [RID_W-1:0]              clr_reg,
    output logic [NUM_WARPS*NUM_REGS-1:0] pend
);
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic hit_set, hit_clr;
            // Decode which requests address this bit.
            always_comb begin
                hit_set = (set_warp == WID_W'(w)) &&
                          ((set0_en && set0_reg == RID_W'(r)) ||
                           (set1_en && set1_reg == RID_W'(r)));
                hit_clr = clr_en && clr_warp == WID_W'(w) && clr_reg == RID_W'(r);
            end
            // Hold the pending bit; set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)       pend[w*NUM_REGS+r] <= 1'b0;
                else if (hit_set) pend[w*NUM_REGS+r] <= 1'b1;
                else if (hit_clr) pend[w*NUM_REGS+r] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wis_hazard.sv
// Module: eligibility check of one warp. Decides whether the head may issue
// and, in the dual variant, whether the pair may issue with it.
// Assumes busy_ext already marks unimplemented unit codes as busy.
module wis_hazard
    import wis_pkg::*;
#(
    parameter int NUM_REGS   = 8,
    parameter bit DUAL_ISSUE = 1'b1
) (
    input  logic                ready,
    input  desc_t               head,
    input  logic                pair_valid,
    input  desc_t               pair,
    input  logic [NUM_REGS-1:0] pend_row,
    input  logic [(1<<UNIT_W)-1:0] busy_ext,
    output logic                elig,
    output logic                pair_ok
);
    logic head_blocked;

    // Head is blocked if any register it touches waits on a load.
    always_comb begin
        head_blocked = pend_row[head.src0] | pend_row[head.src1] | pend_row[head.dst];
        elig = ready & ~head_blocked & ~busy_ext[head.unit];
    end

    if (DUAL_ISSUE) begin : g_dual
        // Pair must be independent of the head and use another free unit set.
        always_comb begin
            pair_ok = pair_valid
                    && (pair.unit != head.unit)
                    && !busy_ext[pair.unit]
                    && (pair.src0 != head.dst)
                    && (pair.src1 != head.dst)
                    && (pair.dst  != head.dst)
                    && !pend_row[pair.src0]
                    && !pend_row[pair.src1]
                    && !pend_row[pair.dst];
        end
    end else begin : g_single
        // Single-issue build never pairs.
        always_comb pair_ok = 1'b0;
    end
endmodule

// File: rtl/wis_rr_pick.sv
// Module: round-robin picker. Grants the first requester after index `last`,
// wrapping around. Purely combinational.
module wis_rr_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);
    // Scan from last+1 onwards and take the first request seen.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int unsigned pos;
            pos = (int'(last) + k) % N;
            if (!gnt_valid && req[pos]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(pos);
            end
        end
    end
endmodule

// File: rtl/wis_issue_top.sv
// Module: warp issue scheduler top. Checks each warp for hazards, picks one
// eligible warp round-robin, optionally pairs its second instruction, and
// keeps the pending-load scoreboard. Issue outputs are combinational from
// inputs and state; no cycle is spent when the issuing warp changes.
// Assumes the fetch side advances a warp by the number of issued slots.
module wis_issue_top
    import wis_pkg::*;
#(
    parameter int NUM_WARPS  = 4,
    parameter int NUM_UNITS  = 3,
    parameter int LOAD_UNIT  = 2,
    parameter bit DUAL_ISSUE = 1'b1,
    localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int UCODES = 1 << UNIT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WARPS-1:0]        warp_ready,
    input  logic [NUM_WARPS*DESC_W-1:0] head_desc,
    input  logic [NUM_WARPS-1:0]        pair_valid,
    input  logic [NUM_WARPS*DESC_W-1:0] pair_desc,
    input  logic [NUM_UNITS-1:0]        unit_busy,
    input  logic                        ret_valid,
    input  logic [WID_W-1:0]            ret_warp,
    input  logic [REG_W-1:0]            ret_reg,
    output logic [1:0]                  issue_valid,
    output logic [WID_W-1:0]            issue_warp,
    output logic [UNIT_W-1:0]           issue_unit0,
    output logic [UNIT_W-1:0]           issue_unit1
);
    desc_t                          hd [NUM_WARPS];
    desc_t                          pd [NUM_WARPS];
    logic [NUM_WARPS-1:0]           elig;
    logic [NUM_WARPS-1:0]           pair_ok;
    logic [NUM_WARPS*NUM_REGS-1:0]  pend_vec;
    logic [UCODES-1:0]              busy_ext;
    logic [WID_W-1:0]               last_q;
    logic                           gnt_valid;
    logic [WID_W-1:0]               gnt_idx;
    desc_t                          sel_head;
    desc_t                          sel_pair;

    // Unit codes without a unit set read as permanently busy.
    always_comb begin
        busy_ext = '1;
        busy_ext[NUM_UNITS-1:0] = unit_busy;
    end

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        assign hd[g] = head_desc[g*DESC_W +: DESC_W];
        assign pd[g] = pair_desc[g*DESC_W +: DESC_W];

        wis_hazard #(
            .NUM_REGS   (NUM_REGS),
            .DUAL_ISSUE (DUAL_ISSUE)
        ) u_hz (
            .ready      (warp_ready[g]),
            .head       (hd[g]),
            .pair_valid (pair_valid[g]),
            .pair       (pd[g]),
            .pend_row   (pend_vec[g*NUM_REGS +: NUM_REGS]),
            .busy_ext   (busy_ext),
            .elig       (elig[g]),
            .pair_ok    (pair_ok[g])
        );
    end

    wis_rr_pick #(.N(NUM_WARPS)) u_rr (
        .req       (elig),
        .last      (last_q),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    // Drive the issue slots from the granted warp.
    always_comb begin
        sel_head       = hd[gnt_idx];
        sel_pair       = pd[gnt_idx];
        issue_valid[0] = rst_n & gnt_valid;
        issue_valid[1] = rst_n & gnt_valid & pair_ok[gnt_idx];
        issue_warp     = gnt_idx;
        issue_unit0    = sel_head.unit;
        issue_unit1    = sel_pair.unit;
    end

    // Remember the last issuing warp for round-robin fairness.
    always_ff @(posedge clk) begin
        if (!rst_n)              last_q <= WID_W'(NUM_WARPS - 1);
        else if (issue_valid[0]) last_q <= gnt_idx;
    end

    wis_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_REGS  (NUM_REGS)
    ) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set0_en  (issue_valid[0] && sel_head.unit == UNIT_W'(LOAD_UNIT)),
        .set1_en  (issue_valid[1] && sel_pair.unit == UNIT_W'(LOAD_UNIT)),
        .set_warp (gnt_idx),
        .set0_reg (sel_head.dst),
        .set1_reg (sel_pair.dst),
        .clr_en   (ret_valid),
        .clr_warp (ret_warp),
        .clr_reg  (ret_reg),
        .pend     (pend_vec)
    );
endmodule

// File: rtl/wis_issue_chk.sv
// Module: property checker for the warp issue scheduler, bound to the top.
// Observes issue ports, inputs and the scoreboard vector.
module wis_issue_chk
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int NUM_UNITS = 3,
    localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_WARPS-1:0]          warp_ready,
    input logic [NUM_WARPS*DESC_W-1:0]   head_desc,
    input logic [NUM_UNITS-1:0]          unit_busy,
    input logic [1:0]                    issue_valid,
    input logic [WID_W-1:0]              issue_warp,
    input logic [UNIT_W-1:0]             issue_unit0,
    input logic [UNIT_W-1:0]             issue_unit1,
    input logic [NUM_WARPS*NUM_REGS-1:0] pend
);
    desc_t                  cur;
    logic [NUM_REGS-1:0]    row;
    logic [(1<<UNIT_W)-1:0] busy_x;

    // Gather the issuing warp's head, its pending row and extended busy flags.
    always_comb begin
        cur    = head_desc[issue_warp*DESC_W +: DESC_W];
        row    = pend[issue_warp*NUM_REGS +: NUM_REGS];
        busy_x = '1;
        busy_x[NUM_UNITS-1:0] = unit_busy;
    end

    // R8
    slot1_needs_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid[1] |-> issue_valid[0]);

    // R7
    dual_units_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid[1] |-> (issue_unit0 != issue_unit1) && !busy_x[issue_unit1]);

    // R2
    issuer_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid[0] |-> warp_ready[issue_warp] && !busy_x[issue_unit0]);

    // R2
    idle_when_none_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_ready == '0) |-> (issue_valid == 2'b00));

    // R4
    no_pending_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid[0] |-> !(row[cur.src0] || row[cur.src1] || row[cur.dst]));
endmodule

bind wis_issue_top wis_issue_chk #(
    .NUM_WARPS (NUM_WARPS),
    .NUM_UNITS (NUM_UNITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .warp_ready  (warp_ready),
    .head_desc   (head_desc),
    .unit_busy   (unit_busy),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_unit0 (issue_unit0),
    .issue_unit1 (issue_unit1),
    .pend        (pend_vec)
);

// File: tb/tb_wis_issue_top.sv
`timescale 1ns/1ps
// Bench: driver task queues the expected issue result per vector, monitor
// pops and compares it shortly after the input-change edge.
module tb_wis_issue_top;
    localparam int W  = 4;
    localparam int DW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  ready = '0;
    logic [W-1:0]  pvld = '0;
    logic [DW-1:0] hd [W];
    logic [DW-1:0] pd [W];
    logic [W*DW-1:0] head_flat, pair_flat;
    logic [2:0]    busy = '0;
    logic          ret_valid = 1'b0;
    logic [1:0]    ret_warp = '0;
    logic [2:0]    ret_reg = '0;
    logic [1:0]    issue_valid;
    logic [1:0]    issue_warp;
    logic [1:0]    issue_unit0, issue_unit1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] v;
        logic [1:0] w;
        logic [1:0] u0;
        logic [1:0] u1;
        string      tag;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    // Pack per-warp descriptors onto the flat buses.
    always_comb begin
        for (int g = 0; g < W; g++) begin
            head_flat[g*DW +: DW] = hd[g];
            pair_flat[g*DW +: DW] = pd[g];
        end
    end

    wis_issue_top dut (
        .clk(clk), .rst_n(rst_n), .warp_ready(ready), .head_desc(head_flat),
        .pair_valid(pvld), .pair_desc(pair_flat), .unit_busy(busy),
        .ret_valid(ret_valid), .ret_warp(ret_warp), .ret_reg(ret_reg),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_unit0(issue_unit0), .issue_unit1(issue_unit1)
    );

    // Descriptor: unit [10:9], dst [8:6], src1 [5:3], src0 [2:0] (R9).
    function automatic logic [DW-1:0] mk(int unit, int dst, int s1, int s0);
        return {2'(unit), 3'(dst), 3'(s1), 3'(s0)};
    endfunction

    task automatic defaults();
        ready = '0; pvld = '0; busy = '0; ret_valid = 1'b0;
        for (int g = 0; g < W; g++) begin
            hd[g] = mk(0, 1, 2, 3);
            pd[g] = mk(0, 1, 2, 3);
        end
    endtask

    // Queue an expected result for the vector now on the inputs, then advance.
    task automatic step(logic [1:0] v, logic [1:0] w, logic [1:0] u0,
                        logic [1:0] u1, string tag);
        exp_t e;
        e.v = v; e.w = w; e.u0 = u0; e.u1 = u1; e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare outputs 1 ns after each input-change edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                n_checks++;
                if (issue_valid !== e.v ||
                    (e.v[0] && (issue_warp !== e.w || issue_unit0 !== e.u0)) ||
                    (e.v[1] && issue_unit1 !== e.u1)) begin
                    n_fail++;
                    $display("FAIL %s: got v=%b w=%0d u0=%0d u1=%0d, expected v=%b w=%0d u0=%0d u1=%0d",
                             e.tag, issue_valid, issue_warp, issue_unit0, issue_unit1,
                             e.v, e.w, e.u0, e.u1);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        defaults();
        @(negedge clk);
        // R1: quiet during reset even with every warp ready.
        ready = '1;
        step(2'b00, 0, 0, 0, "R1 reset");
        step(2'b00, 0, 0, 0, "R1 reset");
        rst_n = 1'b1;
        // R1/R3: warp 0 first, then rotation with wrap.
        step(2'b01, 0, 0, 0, "R1 first warp");
        step(2'b01, 1, 0, 0, "R3 rr");
        step(2'b01, 2, 0, 0, "R3 rr");
        step(2'b01, 3, 0, 0, "R3 rr");
        step(2'b01, 0, 0, 0, "R3 rr wrap");
        ready = 4'b0101;
        step(2'b01, 2, 0, 0, "R3 skip idle");
        step(2'b01, 0, 0, 0, "R3 skip idle");
        // R2: busy unit set is skipped, free set used by another warp.
        ready = '1; busy = 3'b001; hd[2] = mk(1, 1, 2, 3);
        step(2'b01, 2, 1, 0, "R2 busy unit");
        defaults();
        step(2'b00, 0, 0, 0, "R2 none ready");
        // R4: load sets pending, dependent head parked, other warp issues.
        ready = 4'b0010; hd[1] = mk(2, 5, 0, 0);
        step(2'b01, 1, 2, 0, "R4 load issue");
        hd[1] = mk(0, 1, 0, 5);
        step(2'b00, 0, 0, 0, "R4 dependent parked");
        ready = 4'b1010;
        step(2'b01, 3, 0, 0, "R4 switch");
        // R6: independent work continues.
        ready = 4'b0010; hd[1] = mk(0, 2, 3, 4);
        step(2'b01, 1, 0, 0, "R6 no stall");
        // R10: return for another warp does not clear warp 1.
        hd[1] = mk(0, 1, 0, 5);
        ret_valid = 1'b1; ret_warp = 2'd0; ret_reg = 3'd5;
        step(2'b00, 0, 0, 0, "R10 other warp return");
        ret_valid = 1'b0;
        step(2'b00, 0, 0, 0, "R10 still pending");
        // R5: clear takes effect the next cycle.
        ret_valid = 1'b1; ret_warp = 2'd1; ret_reg = 3'd5;
        step(2'b00, 0, 0, 0, "R5 return cycle");
        ret_valid = 1'b0;
        step(2'b01, 1, 0, 0, "R5 after return");
        // R4: write-after-pending-load blocks.
        ready = 4'b0100; hd[2] = mk(2, 6, 0, 0);
        step(2'b01, 2, 2, 0, "R4 load w2");
        hd[2] = mk(0, 6, 1, 0);
        step(2'b00, 0, 0, 0, "R4 dst pending");
        // R7: dual issue and its conditions.
        ready = 4'b0001; pvld = 4'b0001;
        hd[0] = mk(0, 1, 2, 3); pd[0] = mk(1, 4, 5, 6);
        step(2'b11, 0, 0, 1, "R7 dual");
        pd[0] = mk(1, 4, 5, 1);
        step(2'b01, 0, 0, 0, "R7 pair reads head dst");
        pd[0] = mk(0, 4, 5, 6);
        step(2'b01, 0, 0, 0, "R7 same unit");
        pd[0] = mk(1, 4, 5, 6); busy = 3'b010;
        step(2'b01, 0, 0, 0, "R7 pair unit busy");
        busy = '0; pd[0] = mk(1, 1, 5, 6);
        step(2'b01, 0, 0, 0, "R7 same dst");
        pd[0] = mk(2, 7, 2, 3);
        step(2'b11, 0, 0, 2, "R7 pair load");
        pvld = '0; hd[0] = mk(0, 2, 7, 0);
        step(2'b00, 0, 0, 0, "R4 pair load pending");
        pvld = 4'b0001; hd[0] = mk(0, 1, 2, 3); pd[0] = mk(1, 4, 7, 5);
        step(2'b01, 0, 0, 0, "R7 pair pending");
        // R3/R8: rotation continues after warp 0.
        defaults(); ready = '1;
        step(2'b01, 1, 0, 0, "R8 single slot");
        defaults();
        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule